// File: doc/BRIEF.md
# Region Coherence Directory Controller

This block arbitrates coherence permission between a CPU cluster and a GPU cluster at the granularity of a whole region: 1 KB, sixteen 64-byte blocks. Each cluster's region buffer sends a permission request for a region number, asking for either read-only (shared) or read-write (private) access. The directory looks the region up in a set-associative tag store. Each entry holds a region tag, a stable state and one presence bit per cluster. The directory then grants the permission straight away or first probes the other cluster. A probe either invalidates the region there or downgrades it to read-only. The grant goes out only after every probed cluster has acknowledged.

Accepted requests wait in an in-order conflict queue. Only one transaction is worked on at a time, so requests to the same region never overtake each other. Outstanding probes are recorded in a small table indexed by probe ID, and each entry holds the set of clusters still owing an acknowledgement. Data returned with a grant is represented only by the response token, which carries the requester's cluster and transaction ID.

Top module: `region_dir`

## Requirements
- R1: After reset, req_ready_o is 1 and neither prb_valid_o nor rsp_valid_o is asserted.
- R2: A request whose region misses while its set has a free way is granted the requested permission without any probe. The response carries the requester cluster (0 = CPU, 1 = GPU), its transaction ID, and rsp_excl_o equal to req_excl_i.
- R3: A private request (req_excl_i = 1) to a region that the other cluster holds sends one probe with prb_inv_o = 1, addressed to the other cluster only. In prb_dst_o, bit 0 is the CPU and bit 1 is the GPU. Afterwards the requester alone holds the region private, so a later shared request from the other cluster draws a downgrade probe.
- R4: A shared request to a region that the other cluster holds private sends one probe with prb_inv_o = 0 to that cluster. Afterwards both clusters hold the region shared.
- R5: A shared request to a region that the other cluster holds shared or does not hold is granted without a probe.
- R6: A private request to a region that the other cluster does not hold is granted without a probe.
- R7: A miss in a full set evicts a victim way chosen round-robin per set. The pointer starts at way 0 and advances after each eviction, and allocation into a set with room uses the lowest free way. Every holder of the victim region (region number on prb_rgn_o) receives an invalidate before the new region is granted.
- R8: No response is sent until every cluster named in the probe has acknowledged with the probe's ID. An acknowledgement with another ID, or from a cluster that was not probed, has no effect.
- R9: Responses leave in the order their requests were accepted.
- R10: The queue holds QDEPTH (32) accepted requests that are not yet in service. When it is full, req_ready_o is 0 and no further request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Permission request valid |
| req_ready_o | output | 1 | Queue can accept a request |
| req_cl_i | input | 1 | Requesting cluster, 0 CPU, 1 GPU |
| req_excl_i | input | 1 | 1 private (read-write), 0 shared (read-only) |
| req_rgn_i | input | RGN_W (30) | Region number, physical address bits above the region offset |
| req_tid_i | input | TID_W (5) | Requester transaction ID |
| prb_valid_o | output | 1 | Probe pulse |
| prb_dst_o | output | 2 | Probed clusters, bit 0 CPU, bit 1 GPU |
| prb_inv_o | output | 1 | 1 invalidate, 0 downgrade to shared |
| prb_rgn_o | output | RGN_W (30) | Probed region number |
| prb_id_o | output | PID_W (2) | Probe ID, to be echoed in acknowledgements |
| ack_valid_i | input | 1 | Probe acknowledgement valid |
| ack_cl_i | input | 1 | Acknowledging cluster |
| ack_id_i | input | PID_W (2) | Probe ID being acknowledged |
| rsp_valid_o | output | 1 | Grant response pulse |
| rsp_cl_o | output | 1 | Cluster the grant is for |
| rsp_excl_o | output | 1 | 1 private granted, 0 shared granted |
| rsp_tid_o | output | TID_W (5) | Transaction ID of the granted request |

## Verification
A corrupted presence bit or state shows at the ports no later than the next request to that region. The directory then probes the wrong cluster, probes when it should not, or grants without the probe a correct directory would send. Each scenario therefore ends with a request from the other cluster, which exposes the resulting state within a few cycles. A wrong round-robin pointer or a wrong way choice shows on the next miss in that set, as a probe naming an unexpected victim region. A lost or misrouted acknowledgement shows as a response that comes too early or never comes.

// File: rtl/rdir_pkg.sv
package rdir_pkg;
  typedef enum logic [1:0] {
    RS_INV = 2'b00,
    RS_SHR = 2'b01,
    RS_PRV = 2'b10
  } rstate_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'b00,
    F_LOOK = 2'b01,
    F_WAIT = 2'b10
  } fsm_e;
endpackage

// File: rtl/rdir_fifo.sv
module rdir_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rdir_tags.sv
module rdir_tags
  import rdir_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int TAG_W = 26,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output rstate_e          hit_st_o,
  output logic [1:0]       hit_pres_o,
  output logic             free_o,
  output logic [WAY_W-1:0] free_way_o,
  output logic [WAY_W-1:0] vic_way_o,
  output logic [TAG_W-1:0] vic_tag_o,
  output logic [1:0]       vic_pres_o,
  input  logic             we_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  rstate_e          wr_st_i,
  input  logic [1:0]       wr_pres_i,
  input  logic             rr_adv_i
);
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  rstate_e          st_q   [SETS][WAYS];
  logic [1:0]       pres_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q   [SETS];

  // lowest matching / lowest free way wins
  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    free_o     = 1'b0;
    free_way_o = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (st_q[lk_set_i][w] != RS_INV && tag_q[lk_set_i][w] == lk_tag_i) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
      if (st_q[lk_set_i][w] == RS_INV) begin
        free_o     = 1'b1;
        free_way_o = WAY_W'(w);
      end
    end
  end

  assign hit_st_o   = st_q[lk_set_i][hit_way_o];
  assign hit_pres_o = pres_q[lk_set_i][hit_way_o];
  assign vic_way_o  = rr_q[lk_set_i];
  assign vic_tag_o  = tag_q[lk_set_i][vic_way_o];
  assign vic_pres_o = pres_q[lk_set_i][vic_way_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          st_q[s][w]   <= RS_INV;
          pres_q[s][w] <= '0;
        end
      end
    end else begin
      if (we_i) begin
        tag_q[lk_set_i][wr_way_i]  <= wr_tag_i;
        st_q[lk_set_i][wr_way_i]   <= wr_st_i;
        pres_q[lk_set_i][wr_way_i] <= wr_pres_i;
      end
      if (rr_adv_i)
        rr_q[lk_set_i] <= (rr_q[lk_set_i] == WAY_W'(WAYS-1)) ? '0 : rr_q[lk_set_i] + 1'b1;
    end
  end
endmodule

// File: rtl/rdir_ptrk.sv
module rdir_ptrk #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [1:0]    alloc_mask_i,
  output logic [IW-1:0] new_id_o,
  input  logic          ack_valid_i,
  input  logic          ack_cl_i,
  input  logic [IW-1:0] ack_id_i,
  input  logic [IW-1:0] qry_id_i,
  output logic          busy_o
);
  logic [1:0]    mask_q [N];
  logic [IW-1:0] nxt_q;

  assign new_id_o = nxt_q;
  assign busy_o   = |mask_q[qry_id_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= '0;
      for (int i = 0; i < N; i++) mask_q[i] <= '0;
    end else begin
      if (ack_valid_i) mask_q[ack_id_i][ack_cl_i] <= 1'b0;
      if (alloc_i) begin
        mask_q[nxt_q] <= alloc_mask_i;
        nxt_q <= (nxt_q == IW'(N-1)) ? '0 : nxt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/region_dir.sv
module region_dir
  import rdir_pkg::*;
#(
  parameter int ADDR_W       = 40,
  parameter int REGION_BYTES = 1024,
  parameter int SETS         = 16,
  parameter int WAYS         = 2,
  parameter int QDEPTH       = 32,
  parameter int TID_W        = 5,
  parameter int PT_N         = 4,
  localparam int OFF_W = $clog2(REGION_BYTES),
  localparam int RGN_W = ADDR_W - OFF_W,
  localparam int PID_W = (PT_N > 1) ? $clog2(PT_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_cl_i,
  input  logic             req_excl_i,
  input  logic [RGN_W-1:0] req_rgn_i,
  input  logic [TID_W-1:0] req_tid_i,
  output logic             prb_valid_o,
  output logic [1:0]       prb_dst_o,
  output logic             prb_inv_o,
  output logic [RGN_W-1:0] prb_rgn_o,
  output logic [PID_W-1:0] prb_id_o,
  input  logic             ack_valid_i,
  input  logic             ack_cl_i,
  input  logic [PID_W-1:0] ack_id_i,
  output logic             rsp_valid_o,
  output logic             rsp_cl_o,
  output logic             rsp_excl_o,
  output logic [TID_W-1:0] rsp_tid_o
);
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = RGN_W - SET_W;
  localparam int QW    = 2 + RGN_W + TID_W;

  fsm_e fsm_q;

  // request queue
  logic          q_full, q_empty, q_pop;
  logic [QW-1:0] q_dout;

  rdir_fifo #(.W(QW), .DEPTH(QDEPTH)) u_q (
    .clk_i, .rst_ni,
    .push_i (req_valid_i),
    .din_i  ({req_cl_i, req_excl_i, req_rgn_i, req_tid_i}),
    .full_o (q_full),
    .pop_i  (q_pop),
    .empty_o(q_empty),
    .dout_o (q_dout)
  );
  assign req_ready_o = !q_full;
  assign q_pop       = (fsm_q == F_IDLE) && !q_empty;

  // transaction in service
  logic             cur_cl, cur_excl;
  logic [RGN_W-1:0] cur_rgn;
  logic [TID_W-1:0] cur_tid;
  logic [PID_W-1:0] cur_pid;
  logic [SET_W-1:0] cur_set;
  logic [TAG_W-1:0] cur_tag;
  assign cur_set = cur_rgn[SET_W-1:0];
  assign cur_tag = cur_rgn[RGN_W-1:SET_W];

  // tag store
  logic             t_hit, t_free, t_we, t_rr_adv;
  logic [WAY_W-1:0] t_hit_way, t_free_way, t_vic_way, t_wr_way;
  rstate_e          t_hit_st, t_wr_st;
  logic [1:0]       t_hit_pres, t_vic_pres, t_wr_pres;
  logic [TAG_W-1:0] t_vic_tag;

  rdir_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .lk_set_i  (cur_set),
    .lk_tag_i  (cur_tag),
    .hit_o     (t_hit),
    .hit_way_o (t_hit_way),
    .hit_st_o  (t_hit_st),
    .hit_pres_o(t_hit_pres),
    .free_o    (t_free),
    .free_way_o(t_free_way),
    .vic_way_o (t_vic_way),
    .vic_tag_o (t_vic_tag),
    .vic_pres_o(t_vic_pres),
    .we_i      (t_we),
    .wr_way_i  (t_wr_way),
    .wr_tag_i  (cur_tag),
    .wr_st_i   (t_wr_st),
    .wr_pres_i (t_wr_pres),
    .rr_adv_i  (t_rr_adv)
  );

  // probe tracking
  logic             pt_alloc, pt_busy;
  logic [PID_W-1:0] pt_new_id;

  // decision for the transaction in F_LOOK
  logic             d_need, d_inv;
  logic [1:0]       d_dst, d_pres, req_bit, oth_bit;
  logic [WAY_W-1:0] d_way;
  rstate_e          d_st;
  logic [RGN_W-1:0] d_prgn;
  logic             oth_has;

  rdir_ptrk #(.N(PT_N)) u_ptrk (
    .clk_i, .rst_ni,
    .alloc_i     (pt_alloc),
    .alloc_mask_i(d_dst),
    .new_id_o    (pt_new_id),
    .ack_valid_i,
    .ack_cl_i,
    .ack_id_i,
    .qry_id_i    (cur_pid),
    .busy_o      (pt_busy)
  );

  assign req_bit = cur_cl ? 2'b10 : 2'b01;
  assign oth_bit = cur_cl ? 2'b01 : 2'b10;
  assign oth_has = |(t_hit_pres & oth_bit);

  always_comb begin
    d_need = 1'b0;
    d_inv  = 1'b1;
    d_dst  = oth_bit;
    d_prgn = cur_rgn;
    d_st   = cur_excl ? RS_PRV : RS_SHR;
    d_pres = req_bit;
    d_way  = t_free_way;
    if (t_hit) begin
      d_way = t_hit_way;
      if (cur_excl) begin
        d_need = oth_has;
      end else begin
        d_need = oth_has && (t_hit_st == RS_PRV);
        d_inv  = 1'b0;
        d_pres = req_bit | (oth_has ? oth_bit : 2'b00);
      end
    end else if (!t_free) begin
      // full set: invalidate every holder of the round-robin victim
      d_need = 1'b1;
      d_dst  = t_vic_pres;
      d_way  = t_vic_way;
      d_prgn = {t_vic_tag, cur_set};
    end
  end

  logic             pend_wr;
  logic [WAY_W-1:0] pend_way;
  rstate_e          pend_st;
  logic [1:0]       pend_pres;

  assign pend_wr   = (fsm_q == F_WAIT) && !pt_busy;
  assign t_we      = ((fsm_q == F_LOOK) && !d_need) || pend_wr;
  assign t_wr_way  = (fsm_q == F_LOOK) ? d_way  : pend_way;
  assign t_wr_st   = (fsm_q == F_LOOK) ? d_st   : pend_st;
  assign t_wr_pres = (fsm_q == F_LOOK) ? d_pres : pend_pres;
  assign t_rr_adv  = (fsm_q == F_LOOK) && !t_hit && !t_free;
  assign pt_alloc  = (fsm_q == F_LOOK) && d_need;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q       <= F_IDLE;
      cur_cl      <= 1'b0;
      cur_excl    <= 1'b0;
      cur_rgn     <= '0;
      cur_tid     <= '0;
      cur_pid     <= '0;
      pend_way    <= '0;
      pend_st     <= RS_INV;
      pend_pres   <= '0;
      prb_valid_o <= 1'b0;
      prb_dst_o   <= '0;
      prb_inv_o   <= 1'b0;
      prb_rgn_o   <= '0;
      prb_id_o    <= '0;
      rsp_valid_o <= 1'b0;
      rsp_cl_o    <= 1'b0;
      rsp_excl_o  <= 1'b0;
      rsp_tid_o   <= '0;
    end else begin
      prb_valid_o <= 1'b0;
      rsp_valid_o <= 1'b0;
      case (fsm_q)
        F_IDLE: if (!q_empty) begin
          {cur_cl, cur_excl, cur_rgn, cur_tid} <= q_dout;
          fsm_q <= F_LOOK;
        end
        F_LOOK: begin
          pend_way  <= d_way;
          pend_st   <= d_st;
          pend_pres <= d_pres;
          if (d_need) begin
            prb_valid_o <= 1'b1;
            prb_dst_o   <= d_dst;
            prb_inv_o   <= d_inv;
            prb_rgn_o   <= d_prgn;
            prb_id_o    <= pt_new_id;
            cur_pid     <= pt_new_id;
            fsm_q       <= F_WAIT;
          end else begin
            rsp_valid_o <= 1'b1;
            rsp_cl_o    <= cur_cl;
            rsp_excl_o  <= cur_excl;
            rsp_tid_o   <= cur_tid;
            fsm_q       <= F_IDLE;
          end
        end
        F_WAIT: if (!pt_busy) begin
          rsp_valid_o <= 1'b1;
          rsp_cl_o    <= cur_cl;
          rsp_excl_o  <= cur_excl;
          rsp_tid_o   <= cur_tid;
          fsm_q       <= F_IDLE;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/region_dir_chk.sv
module region_dir_chk
  import rdir_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prb_valid_o,
  input logic [1:0] prb_dst_o,
  input logic       rsp_valid_o,
  input fsm_e       fsm_q,
  input logic       t_hit,
  input rstate_e    t_hit_st,
  input logic [1:0] t_hit_pres,
  input logic       pt_busy
);
  // R8
  rsp_after_acks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !pt_busy);

  // R3
  one_probe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prb_valid_o |=> !prb_valid_o);

  // R7
  probe_dst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prb_valid_o |-> prb_dst_o != 2'b00);

  // R6
  priv_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == F_LOOK && t_hit) |->
      (t_hit_st != RS_INV) && (t_hit_st != RS_PRV || $countones(t_hit_pres) == 1));

  // R9
  rsp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R8
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prb_valid_o && rsp_valid_o));
endmodule

bind region_dir region_dir_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .prb_valid_o(prb_valid_o),
  .prb_dst_o  (prb_dst_o),
  .rsp_valid_o(rsp_valid_o),
  .fsm_q      (fsm_q),
  .t_hit      (t_hit),
  .t_hit_st   (t_hit_st),
  .t_hit_pres (t_hit_pres),
  .pt_busy    (pt_busy)
);

// File: tb/sim_region_dir.sv
module sim_region_dir;
  localparam int RGN_W = 30;
  localparam int TID_W = 5;
  localparam int PID_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_cl = 1'b0, req_excl = 1'b0;
  logic [RGN_W-1:0] req_rgn = '0;
  logic [TID_W-1:0] req_tid = '0;
  logic ack_valid = 1'b0, ack_cl = 1'b0;
  logic [PID_W-1:0] ack_id = '0;
  logic req_ready, prb_valid, prb_inv, rsp_valid, rsp_cl, rsp_excl;
  logic [1:0] prb_dst;
  logic [RGN_W-1:0] prb_rgn;
  logic [PID_W-1:0] prb_id;
  logic [TID_W-1:0] rsp_tid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [TID_W-1:0] tidc = '0;

  always #5 clk = ~clk;

  region_dir u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_cl_i(req_cl),
    .req_excl_i(req_excl), .req_rgn_i(req_rgn), .req_tid_i(req_tid),
    .prb_valid_o(prb_valid), .prb_dst_o(prb_dst), .prb_inv_o(prb_inv),
    .prb_rgn_o(prb_rgn), .prb_id_o(prb_id),
    .ack_valid_i(ack_valid), .ack_cl_i(ack_cl), .ack_id_i(ack_id),
    .rsp_valid_o(rsp_valid), .rsp_cl_o(rsp_cl), .rsp_excl_o(rsp_excl), .rsp_tid_o(rsp_tid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_req(input logic c, input logic x, input logic [RGN_W-1:0] rg,
                          input logic [TID_W-1:0] t);
    @(negedge clk);
    req_valid = 1'b1; req_cl = c; req_excl = x; req_rgn = rg; req_tid = t;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_ack(input logic c, input logic [PID_W-1:0] id);
    @(negedge clk);
    ack_valid = 1'b1; ack_cl = c; ack_id = id;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic quiet(input int n, input string rq);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rsp_valid) seen = 1;
    end
    chk(!seen, rq, "response before all acks", 64'(seen), 0);
  endtask

  // one request; edst = expected probe targets (0 = none)
  task automatic txn(input logic c, input logic x, input logic [RGN_W-1:0] rg,
                     input logic [1:0] edst, input logic einv,
                     input logic [RGN_W-1:0] ergn, input string rq);
    bit got_p = 0, got_r = 0;
    int n = 0;
    logic [TID_W-1:0] t = tidc;
    logic [PID_W-1:0] pid;
    tidc = tidc + 1'b1;
    send_req(c, x, rg, t);
    while (!got_p && !got_r && n < 60) begin
      if (prb_valid) got_p = 1;
      else if (rsp_valid) got_r = 1;
      else begin @(negedge clk); n++; end
    end
    chk(got_p == (edst != 0), rq, "probe issued", 64'(got_p), 64'(edst != 0));
    if (got_p) begin
      pid = prb_id;
      chk(prb_dst == edst, rq, "probe targets", 64'(prb_dst), 64'(edst));
      chk(prb_inv == einv, rq, "probe kind", 64'(prb_inv), 64'(einv));
      chk(prb_rgn == ergn, rq, "probe region", 64'(prb_rgn), 64'(ergn));
      // stray acks: wrong id, and a cluster that was not probed
      send_ack(edst[0] ? 1'b0 : 1'b1, pid ^ 2'b01);
      if (edst != 2'b11) send_ack(edst[0] ? 1'b1 : 1'b0, pid);
      quiet(4, "R8");
      if (edst == 2'b11) begin
        send_ack(1'b0, pid);
        quiet(4, "R8");
        send_ack(1'b1, pid);
      end else begin
        send_ack(edst[1], pid);
      end
      n = 0;
      while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
      got_r = rsp_valid;
    end
    chk(got_r, rq, "response seen", 64'(got_r), 1);
    chk(rsp_cl == c && rsp_tid == t && rsp_excl == x, rq, "response fields",
        {rsp_cl, rsp_excl, 3'b0, rsp_tid}, {c, x, 3'b0, t});
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 1);
    chk(prb_valid == 1'b0 && rsp_valid == 1'b0, "R1", "outputs idle after reset",
        {prb_valid, rsp_valid}, 0);

    // sweep: prior holder pattern x requester x permission
    for (int p = 0; p < 6; p++)
      for (int c = 0; c < 2; c++)
        for (int x = 0; x < 2; x++) begin
          automatic int k = p * 4 + c * 2 + x;
          automatic logic [RGN_W-1:0] rg = RGN_W'(k);
          automatic logic [1:0] pm = 2'b00;
          automatic bit pp = 0;
          automatic int o = 1 - c;
          automatic bit oh;
          automatic logic [1:0] ed;
          automatic bit priv;
          automatic string rq;
          case (p)
            1: begin txn(1'b0, 1'b0, rg, 2'b00, 1'b0, rg, "R2"); pm = 2'b01; end
            2: begin txn(1'b1, 1'b0, rg, 2'b00, 1'b0, rg, "R2"); pm = 2'b10; end
            3: begin
              txn(1'b0, 1'b0, rg, 2'b00, 1'b0, rg, "R2");
              txn(1'b1, 1'b0, rg, 2'b00, 1'b0, rg, "R5");
              pm = 2'b11;
            end
            4: begin txn(1'b0, 1'b1, rg, 2'b00, 1'b0, rg, "R2"); pm = 2'b01; pp = 1; end
            5: begin txn(1'b1, 1'b1, rg, 2'b00, 1'b0, rg, "R2"); pm = 2'b10; pp = 1; end
            default: ;
          endcase
          oh = pm[o];
          if (x != 0) ed = oh ? 2'(1 << o) : 2'b00;
          else        ed = (oh && pp) ? 2'(1 << o) : 2'b00;
          if (p == 0) rq = "R2";
          else if (ed != 0) rq = (x != 0) ? "R3" : "R4";
          else rq = (x != 0) ? "R6" : "R5";
          txn(1'(c), 1'(x), rg, ed, 1'(x), rg, rq);
          priv = (x != 0);
          // expose the resulting state through a shared request from the other cluster
          txn(1'(o), 1'b0, rg, priv ? 2'(1 << c) : 2'b00, 1'b0, rg, priv ? "R3" : "R4");
        end

    // eviction order in set 3
    do_reset();
    txn(1'b0, 1'b0, 30'd3,  2'b00, 1'b0, 30'd3,  "R2");
    txn(1'b1, 1'b1, 30'd19, 2'b00, 1'b0, 30'd19, "R2");
    txn(1'b0, 1'b0, 30'd35, 2'b01, 1'b1, 30'd3,  "R7");
    txn(1'b1, 1'b0, 30'd51, 2'b10, 1'b1, 30'd19, "R7");
    txn(1'b1, 1'b0, 30'd35, 2'b00, 1'b0, 30'd35, "R5");
    txn(1'b0, 1'b1, 30'd67, 2'b11, 1'b1, 30'd35, "R7");
    txn(1'b0, 1'b1, 30'd3,  2'b10, 1'b1, 30'd51, "R7");

    // queue full and ordering
    do_reset();
    txn(1'b0, 1'b1, 30'd40, 2'b00, 1'b0, 30'd40, "R6");
    send_req(1'b1, 1'b1, 30'd40, 5'd7);
    begin
      int n = 0;
      while (!prb_valid && n < 60) begin @(negedge clk); n++; end
      chk(prb_valid && prb_dst == 2'b01, "R3", "blocking probe", {prb_valid, prb_dst}, 3'b101);
    end
    begin
      logic [PID_W-1:0] pid = prb_id;
      bit ok_all = 1;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        req_valid = 1'b1; req_cl = 1'b0; req_excl = 1'b0; req_rgn = 30'd41; req_tid = TID_W'(i);
        if (!req_ready) ok_all = 0;
      end
      chk(ok_all, "R10", "ready while filling", 64'(ok_all), 1);
      @(negedge clk);
      req_tid = 5'd9;
      chk(req_ready == 1'b0, "R10", "ready when full", 64'(req_ready), 0);
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0, "R10", "ready stays low", 64'(req_ready), 0);
      req_valid = 1'b0;
      send_ack(1'b0, pid);
    end
    begin
      int got = 0;
      bit ord = 1;
      bit prb_seen = 0;
      for (int n = 0; n < 400; n++) begin
        @(negedge clk);
        if (prb_valid) prb_seen = 1;
        if (rsp_valid) begin
          if (got == 0) begin
            if (!(rsp_cl == 1'b1 && rsp_tid == 5'd7 && rsp_excl == 1'b1)) ord = 0;
          end else if (!(rsp_cl == 1'b0 && rsp_tid == TID_W'(got - 1) && rsp_excl == 1'b0)) begin
            ord = 0;
          end
          got++;
        end
      end
      chk(ord, "R9", "response order", 64'(ord), 1);
      chk(got == 33, "R10", "responses after drain", 64'(got), 33);
      chk(!prb_seen, "R5", "no probe while draining", 64'(prb_seen), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule